// File: doc/BRIEF.md
# Interrupt Line Edge Detector with Noise Filter

This block sits between a bank of interrupt-capable general-purpose pins and a downstream interrupt controller. Each line is brought into the clock domain and then goes through its own glitch filter. A small control window decides what each line presents downstream. A line can be masked. It can pass its level through, raw or filtered. It can also turn every accepted transition into a falling edge, so that a controller that only senses falling edges still sees both rising and falling activity on the pin.

Software programs four word registers at byte offsets 0x90, 0x94, 0x98 and 0x9C. Neighbouring pin-bank registers sit on either side of this window, so these offsets are fixed. The three per-line registers hold one bit per line, with line i at bit i. The fourth register holds a single stability count that every filter uses. The data readback path of the pins does not pass through this block, so the filter has no effect on it.

Top module: `irqf_edge_front`

## Requirements
- R1: After a synchronous active-low reset, all four control registers read 0 and every `line_out` bit is 0.
- R2: The line-enable register is at 0x90, the both-edge register at 0x94, the filter-enable register at 0x98 and the shared stability count at 0x9C. Bits above NUM_LINES (per-line registers) or above CNT_W (count) read 0. Any other address reads 0. A write to any other address changes no register.
- R3: A line whose enable bit is 0 drives its idle level whatever its input does. The idle level is 0 when its both-edge bit is 0 and 1 when its both-edge bit is 1.
- R4: A line that is enabled, with both-edge and filter bits at 0, shows `line_in` on `line_out` delayed by SYNC_STAGES+1 clock cycles.
- R5: With the filter bit set, the filtered level takes a new value only after the synchronized input has held that value for `count` consecutive cycles. A shorter excursion never reaches `line_out`.
- R6: An enabled line with both-edge and filter bits set rests at 1. Each accepted transition, rising or falling, gives one single-cycle 0 pulse.
- R7: An enabled line with its both-edge bit set and its filter bit clear stays at 1 and produces no pulses.
- R8: All lines use the one count value, and each line's filter runs independently on its own input.
- R9: A count of 0 behaves like a count of 1: a new level is accepted after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| line_in | input | NUM_LINES | Interrupt-capable pin levels |
| line_out | output | NUM_LINES | Per-line level or event output to the interrupt controller |

## Verification
The bench builds the block with all 24 lines, so the highest bit of every per-line register is exercised, along with two synchronizer stages and a 4-bit count. The narrow count lets a wide write show the truncation of the count field. It also brings the largest count, 15, within reach of short directed runs, next to the 0-as-1 case. Random input patterns that flip slowly are compared cycle by cycle against a bench model under every mode mix. Directed single-line runs count output pulses for glitches that are too short to pass and for both-edge toggles with and without the filter.

// File: rtl/irqf_pkg.sv
// Package: shared constants and types for the interrupt edge front end.
// Assumes byte addressing with word-aligned registers.
package irqf_pkg;

    // Register byte offsets; fixed because neighbouring pin-bank registers
    // occupy the addresses on either side of this window.
    localparam int OFS_ARM   = 'h90;
    localparam int OFS_BOTH  = 'h94;
    localparam int OFS_CLEAN = 'h98;
    localparam int OFS_HOLD  = 'h9C;

    // Decoded register selection.
    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_ARM,
        RSEL_BOTH,
        RSEL_CLEAN,
        RSEL_HOLD
    } rsel_e;

    // Per-line control bundle handed to the output shaper.
    typedef struct packed {
        logic arm;
        logic both;
        logic clean;
    } line_ctl_t;

endpackage

// File: rtl/irqf_ctrl_regs.sv
// Module: control register window for the interrupt edge front end.
// Holds the per-line enable, both-edge and filter-enable bits and the
// shared stability count. Reads are combinational; writes take effect at
// the next clock edge. Assumes NUM_LINES and CNT_W do not exceed DATA_W.
module irqf_ctrl_regs
    import irqf_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int CNT_W     = 8,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_LINES-1:0] arm_q,
    output logic [NUM_LINES-1:0] both_q,
    output logic [NUM_LINES-1:0] clean_q,
    output logic [CNT_W-1:0]     hold_q
);

    localparam logic [ADDR_W-1:0] A_ARM   = ADDR_W'(OFS_ARM);
    localparam logic [ADDR_W-1:0] A_BOTH  = ADDR_W'(OFS_BOTH);
    localparam logic [ADDR_W-1:0] A_CLEAN = ADDR_W'(OFS_CLEAN);
    localparam logic [ADDR_W-1:0] A_HOLD  = ADDR_W'(OFS_HOLD);

    rsel_e sel;

    // Address decode into a register selection.
    always_comb begin
        sel = RSEL_NONE;
        if (addr == A_ARM)        sel = RSEL_ARM;
        else if (addr == A_BOTH)  sel = RSEL_BOTH;
        else if (addr == A_CLEAN) sel = RSEL_CLEAN;
        else if (addr == A_HOLD)  sel = RSEL_HOLD;
    end

    // Register update on write strobe; unused data bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q   <= '0;
            both_q  <= '0;
            clean_q <= '0;
            hold_q  <= '0;
        end else if (wr) begin
            case (sel)
                RSEL_ARM:   arm_q   <= wdata[NUM_LINES-1:0];
                RSEL_BOTH:  both_q  <= wdata[NUM_LINES-1:0];
                RSEL_CLEAN: clean_q <= wdata[NUM_LINES-1:0];
                RSEL_HOLD:  hold_q  <= wdata[CNT_W-1:0];
                default:    ;
            endcase
        end
    end

    // Read mux, zero-extended to the bus width.
    always_comb begin
        rdata = '0;
        case (sel)
            RSEL_ARM:   rdata[NUM_LINES-1:0] = arm_q;
            RSEL_BOTH:  rdata[NUM_LINES-1:0] = both_q;
            RSEL_CLEAN: rdata[NUM_LINES-1:0] = clean_q;
            RSEL_HOLD:  rdata[CNT_W-1:0]     = hold_q;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqf_sync.sv
// Module: multi-stage synchronizer for the incoming pin levels.
// Assumes STAGES >= 1; output lags the input by STAGES cycles.
module irqf_sync #(
    parameter int NUM_LINES = 24,
    parameter int STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] din,
    output logic [NUM_LINES-1:0] dout
);

    logic [NUM_LINES-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= din;
            end
        end else begin : g_next
            // Later stages shift the previous stage forward.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/irqf_glitch_filter.sv
// Module: single-line stability filter.
// Accepts a new level once the input has differed from the held level
// for `hold` consecutive cycles (0 treated as 1). `accept` is high in the
// cycle whose closing edge updates the held level.
module irqf_glitch_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level_in,
    input  logic [CNT_W-1:0] hold,
    output logic             stable_q,
    output logic             accept
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   run_len;
    logic             differs;

    // Length of the current run of the differing level, counting this cycle.
    always_comb begin
        differs = (level_in != stable_q);
        run_len = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        accept  = differs && (run_len >= {1'b0, hold});
    end

    // Track the run length and commit the new level when it is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b0;
            cnt_q    <= '0;
        end else if (!differs) begin
            cnt_q <= '0;
        end else if (accept) begin
            stable_q <= level_in;
            cnt_q    <= '0;
        end else begin
            cnt_q <= run_len[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/irqf_line_shaper.sv
// Module: per-line output stage.
// Masked lines rest at the idle level of their mode; level lines pass the
// raw or filtered level; both-edge lines rest high and pulse low for one
// cycle per accepted transition, but only when the filter is enabled.
module irqf_line_shaper
    import irqf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  line_ctl_t ctl,
    input  logic      raw,
    input  logic      filtered,
    input  logic      accept,
    output logic      out_q
);

    logic nxt;

    // Select the next output value from the line's mode.
    always_comb begin
        if (!ctl.arm)       nxt = ctl.both;
        else if (ctl.both)  nxt = ctl.clean ? ~accept : 1'b1;
        else                nxt = ctl.clean ? filtered : raw;
    end

    // Register the output toward the interrupt controller.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= nxt;
    end

endmodule

// File: rtl/irqf_edge_front.sv
// Module: interrupt line edge detector with shared-period noise filter.
// Synchronizes the pins, filters each line, and shapes each line's output
// according to its enable, both-edge and filter-enable bits.
module irqf_edge_front
    import irqf_pkg::*;
#(
    parameter int NUM_LINES   = 24,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] line_in,
    output logic [NUM_LINES-1:0] line_out
);

    logic [NUM_LINES-1:0] arm_q;
    logic [NUM_LINES-1:0] both_q;
    logic [NUM_LINES-1:0] clean_q;
    logic [CNT_W-1:0]     hold_q;
    logic [NUM_LINES-1:0] sync_w;
    logic [NUM_LINES-1:0] stable_w;
    logic [NUM_LINES-1:0] accept_w;

    irqf_ctrl_regs #(
        .NUM_LINES (NUM_LINES),
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .arm_q   (arm_q),
        .both_q  (both_q),
        .clean_q (clean_q),
        .hold_q  (hold_q)
    );

    irqf_sync #(
        .NUM_LINES (NUM_LINES),
        .STAGES    (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_in),
        .dout  (sync_w)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        line_ctl_t ctl;

        assign ctl = '{arm: arm_q[i], both: both_q[i], clean: clean_q[i]};

        irqf_glitch_filter #(
            .CNT_W (CNT_W)
        ) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .level_in (sync_w[i]),
            .hold     (hold_q),
            .stable_q (stable_w[i]),
            .accept   (accept_w[i])
        );

        irqf_line_shaper u_shape (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl      (ctl),
            .raw      (sync_w[i]),
            .filtered (stable_w[i]),
            .accept   (accept_w[i]),
            .out_q    (line_out[i])
        );
    end

endmodule

// File: rtl/irqf_edge_front_checker.sv
// Module: temporal checks for irqf_edge_front, attached by bind.
module irqf_edge_front_checker #(
    parameter int NUM_LINES = 24,
    parameter int CNT_W     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [NUM_LINES-1:0] arm_q,
    input logic [NUM_LINES-1:0] both_q,
    input logic [NUM_LINES-1:0] clean_q,
    input logic [CNT_W-1:0]     hold_q,
    input logic [NUM_LINES-1:0] sync_w,
    input logic [NUM_LINES-1:0] stable_w,
    input logic [NUM_LINES-1:0] line_out
);

    // R1: the cycle after a reset edge shows all outputs low.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (line_out == '0));

    // R2: without a write strobe the control registers keep their value.
    p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(arm_q) && $stable(both_q) && $stable(clean_q) && $stable(hold_q)));

    // R3: masked level-mode lines sit at 0.
    p_masked_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_out & $past(~arm_q & ~both_q)) == '0));

    // R5: the filtered level only ever moves to the synchronized value.
    p_filter_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (((stable_w ^ $past(stable_w)) & (stable_w ^ $past(sync_w))) == '0));

    // R6: a low output on a filtered both-edge line follows a filter update.
    p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~line_out & $past(arm_q & both_q & clean_q) & ~(stable_w ^ $past(stable_w))) == '0));

    // R7: unfiltered both-edge lines never go low.
    p_both_nofilter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((~line_out & $past(arm_q & both_q & ~clean_q)) == '0));

endmodule

bind irqf_edge_front irqf_edge_front_checker #(
    .NUM_LINES (NUM_LINES),
    .CNT_W     (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .arm_q    (arm_q),
    .both_q   (both_q),
    .clean_q  (clean_q),
    .hold_q   (hold_q),
    .sync_w   (sync_w),
    .stable_w (stable_w),
    .line_out (line_out)
);

// File: tb/irqf_edge_front_bench.sv
`timescale 1ns/1ps
module irqf_edge_front_bench;

    localparam int N  = 24;
    localparam int CW = 4;
    localparam int SS = 2;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  line_in = '0;
    logic [N-1:0]  line_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string tag = "R1";

    // Bench model state.
    logic [N-1:0]  m_sync [SS];
    logic [N-1:0]  m_stable = '0;
    logic [CW-1:0] m_cnt [N];
    logic [N-1:0]  m_out = '0;
    logic [N-1:0]  m_arm = '0, m_both = '0, m_clean = '0;
    logic [CW-1:0] m_hold = '0;
    logic [N-1:0]  seen_out;

    always #2.5 clk = ~clk;

    irqf_edge_front #(
        .NUM_LINES (N), .CNT_W (CW), .SYNC_STAGES (SS), .ADDR_W (AW), .DATA_W (DW)
    ) u_irqf_edge_front (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .line_in (line_in), .line_out (line_out)
    );

    function automatic void check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endfunction

    // Expected next output of one line from the requirement rules.
    function automatic logic exp_line(logic arm, logic both, logic clean,
                                      logic raw, logic filt, logic acc);
        if (!arm)  return both;
        if (both)  return clean ? ~acc : 1'b1;
        return clean ? filt : raw;
    endfunction

    // Advance the model by one clock edge with the given inputs.
    function automatic void model_step(logic [N-1:0] lin, logic wr,
                                       logic [AW-1:0] a, logic [DW-1:0] d);
        logic [N-1:0] s, acc, nout;
        s = m_sync[SS-1];
        for (int i = 0; i < N; i++) begin
            logic [CW:0] run;
            run = {1'b0, m_cnt[i]} + 1;
            acc[i] = (s[i] != m_stable[i]) && (run >= {1'b0, m_hold});
            nout[i] = exp_line(m_arm[i], m_both[i], m_clean[i], s[i], m_stable[i], acc[i]);
            if (s[i] == m_stable[i]) m_cnt[i] = '0;
            else if (acc[i]) begin m_stable[i] = s[i]; m_cnt[i] = '0; end
            else m_cnt[i] = run[CW-1:0];
        end
        m_out = nout;
        for (int k = SS-1; k > 0; k--) m_sync[k] = m_sync[k-1];
        m_sync[0] = lin;
        if (wr) begin
            case (a)
                8'h90: m_arm   = d[N-1:0];
                8'h94: m_both  = d[N-1:0];
                8'h98: m_clean = d[N-1:0];
                8'h9C: m_hold  = d[CW-1:0];
                default: ;
            endcase
        end
    endfunction

    // One cycle: compare output, drive inputs, step model, return read data.
    task automatic step(input logic [N-1:0] lin, input logic wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] rd);
        @(negedge clk);
        seen_out = line_out;
        check(tag, DW'(line_out), DW'(m_out));
        line_in = lin; bus_wr = wr; bus_addr = a; bus_wdata = d;
        model_step(lin, wr, a, d);
        #1 rd = bus_rdata;
    endtask

    task automatic idle(input logic [N-1:0] lin);
        logic [DW-1:0] rd;
        step(lin, 1'b0, 8'h00, '0, rd);
    endtask

    task automatic wreg(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] rd;
        step(line_in, 1'b1, a, d, rd);
    endtask

    task automatic rreg(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        logic [DW-1:0] rd;
        step(line_in, 1'b0, a, '0, rd);
        check(req, rd, exp);
    endtask

    task automatic setup(input logic [N-1:0] arm, input logic [N-1:0] both,
                         input logic [N-1:0] clean, input logic [CW-1:0] hold);
        wreg(8'h94, DW'(both));
        wreg(8'h98, DW'(clean));
        wreg(8'h9C, DW'(hold));
        wreg(8'h90, DW'(arm));
    endtask

    // Random run with slowly flipping inputs.
    task automatic rand_run(input int cycles, input int sparsity);
        logic [N-1:0] cur = line_in;
        for (int c = 0; c < cycles; c++) begin
            logic [N-1:0] flip = N'($urandom);
            for (int k = 1; k < sparsity; k++) flip &= N'($urandom);
            cur ^= flip;
            idle(cur);
        end
    endtask

    // Count cycles where line 0 shows the given value.
    task automatic count_line0(input logic [N-1:0] lin, input int cycles,
                               input logic val, inout int cnt);
        for (int c = 0; c < cycles; c++) begin
            idle(lin);
            if (seen_out[0] == val) cnt++;
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < SS; k++) m_sync[k] = '0;
        for (int i = 0; i < N; i++) m_cnt[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values
        tag = "R1";
        rreg("R1", 8'h90, '0); rreg("R1", 8'h94, '0);
        rreg("R1", 8'h98, '0); rreg("R1", 8'h9C, '0);
        check("R1", DW'(line_out), '0);

        // R2: map, truncation, unmapped addresses
        tag = "R2";
        wreg(8'h90, 32'hFFFF_FFFF); rreg("R2", 8'h90, 32'h00FF_FFFF);
        wreg(8'h9C, 32'h0000_00FF); rreg("R2", 8'h9C, 32'h0000_000F);
        wreg(8'h80, 32'h1234_5678); rreg("R2", 8'h80, '0);
        rreg("R2", 8'hA0, '0); rreg("R2", 8'h90, 32'h00FF_FFFF);
        wreg(8'h94, 32'h00A5_5A5A); rreg("R2", 8'h94, 32'h00A5_5A5A);
        setup('0, '0, '0, '0);

        // R4: raw pass-through, all lines
        tag = "R4"; setup('1, '0, '0, '0); rand_run(200, 1);
        // R3: half the lines masked, mixed idle levels
        tag = "R3"; setup(24'h0F0F0F, 24'h3C3C3C, 24'h000000, 4'd0); rand_run(200, 1);
        // R5: filtered level mode, count 5
        tag = "R5"; setup('1, '0, '1, 4'd5); rand_run(300, 3);
        tag = "R5"; setup('1, '0, '1, 4'd15); rand_run(200, 4);
        // R9: count 0
        tag = "R9"; setup('1, '0, '1, 4'd0); rand_run(150, 2);
        // R6 / R7: both-edge with and without filter
        tag = "R6"; setup('1, '1, '1, 4'd3); rand_run(300, 3);
        tag = "R7"; setup('1, '1, '0, 4'd3); rand_run(150, 2);
        // R8: all modes mixed on one shared count
        tag = "R8";
        for (int r = 0; r < 4; r++) begin
            setup(N'($urandom), N'($urandom), N'($urandom), CW'($urandom));
            rand_run(150, 3);
        end

        // Directed single-line cases on line 0.
        begin
            int cnt;
            tag = "R5"; setup(24'h1, '0, 24'h1, 4'd4); line_in = '0;
            repeat (10) idle('0);
            cnt = 0; repeat (3) idle(24'h1); count_line0('0, 20, 1'b1, cnt);
            check("R5 short glitch blocked", DW'(cnt), 0);
            cnt = 0; repeat (4) idle(24'h1); count_line0('0, 20, 1'b1, cnt);
            check("R5 held pulse passes for 4 cycles", DW'(cnt), 4);

            tag = "R9"; wreg(8'h9C, 0); repeat (10) idle('0);
            cnt = 0; idle(24'h1); count_line0('0, 20, 1'b1, cnt);
            check("R9 one-cycle pulse passes", DW'(cnt), 1);

            tag = "R6"; setup(24'h1, 24'h1, 24'h1, 4'd3); repeat (10) idle('0);
            cnt = 0; count_line0(24'h1, 20, 1'b0, cnt);
            check("R6 rising gives one low pulse", DW'(cnt), 1);
            cnt = 0; count_line0('0, 20, 1'b0, cnt);
            check("R6 falling gives one low pulse", DW'(cnt), 1);

            tag = "R7"; wreg(8'h98, 0); repeat (10) idle('0);
            cnt = 0; count_line0(24'h1, 10, 1'b0, cnt); count_line0('0, 10, 1'b0, cnt);
            check("R7 no pulse without filter", DW'(cnt), 0);

            tag = "R3"; setup('0, 24'h1, '0, 4'd0); repeat (5) idle('0);
            cnt = 0; count_line0(24'h1, 10, 1'b0, cnt); count_line0('0, 10, 1'b0, cnt);
            check("R3 masked both-edge line stays at 1", DW'(cnt), 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule